// File: doc/BRIEF.md
# Page Data Scrambler with Address-Derived Keystream

This block sits in the byte stream between a flash channel controller and the array. It combines each data byte with eight bits of a pseudo-random keystream, so that the bits written to the cells come out close to half ones and half zeros whatever the host data looks like. That balance reduces program and read disturb between neighbouring cells. The keystream comes from a 32-bit linear feedback shift register.

The register is loaded at the start of every page from that page's logical address, never from its physical location. A page that internal copy-back or garbage collection has moved to a different block therefore still descrambles correctly. The same logic is used in both directions, because applying the keystream twice cancels it.

A one-cycle strobe with the logical address marks a page start. Bytes then flow through a valid/ready stream with a single register stage.

Top module: `page_scrambler`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The keystream register uses the feedback polynomial x^32+x^22+x^2+x+1. Each step outputs bit 31, computes feedback as bit31^bit21^bit1^bit0, and shifts left with the feedback entering bit 0. Every accepted byte takes 8 steps, and the first output bit is XORed into data bit 7, the next into bit 6, and so on down to bit 0.
- R3: The register advances only on an accepted byte (`in_valid` and `in_ready` both high). Stalled cycles and idle cycles leave the keystream where it was.
- R4: The seed is `page_addr` XOR 32'hA5C3_96E1. When that result is zero (address equal to the constant), the seed is 32'hA5C3_96E1 instead, so the register is never all zeros.
- R5: Passing a scrambled page through again with the same page address returns the original bytes.
- R6: A byte accepted on one clock edge appears on `out_data` with `out_valid` high right after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, and `in_ready` is low.
- R8: A byte accepted in the same cycle as `page_start` is scrambled with the seed of the new address.
- R9: A `page_start` with no byte accepted reloads the seed, and the next accepted byte uses the new seed's first keystream byte.
- R10: `in_ready` is high exactly when the output register is empty or `out_ready` is high, so a continuous stream passes one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_start | input | 1 | One-cycle strobe that reloads the seed |
| page_addr | input | 32 | Logical page address, sampled with `page_start` |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte can be accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Scrambled or descrambled byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
All-zero input exposes the raw keystream, which shows whether the polynomial, the bit order and the 8-step advance are right. Two pages, one at address zero and one at an address equal to the constant, must give identical output, which confirms the zero-seed substitution. A random page fed back through the block must come out unchanged, which shows that the operation inverts itself. Random pages with gaps in `in_valid`, stalls on `out_ready`, and page strobes that arrive alone or together with a byte separate correct keystream advance, reseed timing and hold behaviour from a register that runs free or drops a reload.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int unsigned KEY_W   = 32;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned ADDR_W  = 32;
    // feedback taps for x^32 + x^22 + x^2 + x + 1 (bits 31, 21, 1, 0)
    localparam logic [KEY_W-1:0] TAP_MASK   = 32'h8020_0003;
    localparam logic [KEY_W-1:0] SEED_CONST = 32'hA5C3_96E1;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } beat_t;

    function automatic key_t key_step(input key_t s);
        return {s[KEY_W-2:0], ^(s & TAP_MASK)};
    endfunction
endpackage

// File: rtl/scr_seed_map.sv
module scr_seed_map
    import scr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output key_t              seed
);
    localparam int unsigned PAD_W = KEY_W - ADDR_W;

    key_t mixed;

    generate
        if (PAD_W == 0) begin : g_same
            assign mixed = addr ^ SEED_CONST;
        end else begin : g_pad
            assign mixed = {{PAD_W{1'b0}}, addr} ^ SEED_CONST;
        end
    endgenerate

    // an all-zero register would lock up: fall back to the constant
    assign seed = (mixed == '0) ? SEED_CONST : mixed;
endmodule

// File: rtl/scr_keystream.sv
module scr_keystream
    import scr_pkg::*;
#(
    parameter int unsigned STEPS = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  key_t             seed,
    input  logic             advance,
    output logic [STEPS-1:0] ks,
    output key_t             state_q
);
    key_t src;
    key_t chain [STEPS+1];

    // a reload in the same cycle takes effect for that cycle's byte
    assign src      = load ? seed : state_q;
    assign chain[0] = src;

    generate
        for (genvar i = 0; i < STEPS; i++) begin : g_step
            assign ks[STEPS-1-i] = chain[i][KEY_W-1];
            assign chain[i+1]    = key_step(chain[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED_CONST;
        end else if (advance) begin
            state_q <= chain[STEPS];
        end else if (load) begin
            state_q <= seed;
        end
    end
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  byte_t push_data,
    output logic  can_push,
    input  logic  pop,
    output beat_t q
);
    assign can_push = !q.valid || pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{valid: 1'b0, data: '0};
        end else if (push) begin
            q <= '{valid: 1'b1, data: push_data};
        end else if (pop) begin
            q.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/page_scrambler.sv
module page_scrambler
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              page_start,
    input  logic [ADDR_W-1:0] page_addr,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready
);
    key_t        seed;
    key_t        key_state;
    byte_t       ks;
    logic        accept;
    beat_t       held;

    assign accept = in_valid && in_ready;

    scr_seed_map u_seed (
        .addr (page_addr),
        .seed (seed)
    );

    scr_keystream #(.STEPS(BYTE_W)) u_key (
        .clk     (clk),
        .rst     (rst),
        .load    (page_start),
        .seed    (seed),
        .advance (accept),
        .ks      (ks),
        .state_q (key_state)
    );

    scr_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .push      (accept),
        .push_data (in_data ^ ks),
        .can_push  (in_ready),
        .pop       (out_ready),
        .q         (held)
    );

    assign out_valid = held.valid;
    assign out_data  = held.data;
endmodule

// File: rtl/scr_checker.sv
module scr_checker
    import scr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  page_start,
    input logic  in_valid,
    input logic  in_ready,
    input logic  out_valid,
    input byte_t out_data,
    input logic  out_ready,
    input key_t  key_state
);
    // R6: an accepted byte is presented on the next cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R7: a stalled output holds its value and blocks the input
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r7_block: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R3: no accepted byte and no reload leaves the keystream in place
    a_r3_no_drift: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_ready) && !page_start) |=> $stable(key_state));

    // R4: the register never reaches the lock-up state
    always_ff @(posedge clk) begin
        if (!rst) begin
            a_r4_nonzero: assert (key_state != '0);
        end
    end
endmodule

bind page_scrambler scr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .page_start (page_start),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .key_state  (key_state)
);

// File: tb/page_scrambler_tb.sv
module page_scrambler_tb;
    localparam logic [31:0] K = 32'hA5C3_96E1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        page_start = 1'b0;
    logic [31:0] page_addr = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mst = K;
    logic [7:0]  expq [$];
    string       tagq [$];
    logic [7:0]  got [$];
    bit          pend_chk = 0;
    bit          hold_chk = 0;
    logic [7:0]  hold_val = '0;

    always #10 clk = ~clk;

    page_scrambler u_dut (
        .clk(clk), .rst(rst), .page_start(page_start), .page_addr(page_addr),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    function automatic logic [31:0] m_seed(input logic [31:0] a);
        logic [31:0] t = a ^ K;
        return (t == 0) ? K : t;
    endfunction

    function automatic logic [7:0] m_ks(inout logic [31:0] s);
        logic [7:0] k;
        for (int i = 0; i < 8; i++) begin
            k[7-i] = s[31];
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
        end
        return k;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit ps, input logic [31:0] a, input bit iv,
                       input logic [7:0] d, input bit ordy, input string tag);
        logic [7:0] k;
        @(negedge clk);
        page_start = ps; page_addr = a; in_valid = iv; in_data = d; out_ready = ordy;
        #1;
        if (pend_chk) check(out_valid === 1'b1, "R6 latency", out_valid, 1);
        if (hold_chk) check(out_valid === 1'b1 && out_data === hold_val, "R7 hold", out_data, hold_val);
        check(in_ready === (!out_valid || out_ready), "R10 ready", in_ready, !out_valid || out_ready);
        if (out_valid && out_ready) begin
            if (expq.size() == 0) check(0, "R6 unexpected output", out_data, 0);
            else begin
                string t = tagq.pop_front();
                logic [7:0] e = expq.pop_front();
                check(out_data === e, t, out_data, e);
                got.push_back(out_data);
            end
        end
        hold_chk = out_valid && !out_ready;
        hold_val = out_data;
        if (ps) mst = m_seed(a);
        pend_chk = iv && in_ready;
        if (iv && in_ready) begin
            k = m_ks(mst);
            expq.push_back(d ^ k);
            tagq.push_back(tag);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, "drain");
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] orig [$];
        logic [7:0] b0, b1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);

        // R2: zero data exposes the raw keystream
        cyc(1, 32'h0000_1234, 1, 8'h00, 1, "R2 keystream");
        for (int i = 0; i < 15; i++) cyc(0, 0, 1, 8'h00, 1, "R2 keystream");
        drain();

        // R4: address equal to the constant must behave as address zero
        got.delete();
        cyc(1, K, 1, 8'h00, 1, "R4 zero seed");
        drain();
        cyc(1, 32'h0, 1, 8'h00, 1, "R4 addr zero");
        drain();
        b0 = got[0]; b1 = got[1];
        check(b0 === b1, "R4 substitute seed", b0, b1);

        // R9: strobe alone, then bytes; R3: idle and stall cycles in between
        cyc(1, 32'h00AB_CDEF, 0, 0, 1, "R9 reload");
        cyc(0, 0, 0, 0, 1, "R3 idle");
        cyc(0, 0, 1, 8'h5A, 0, "R9 first byte");
        cyc(0, 0, 1, 8'h33, 0, "R3 stalled");
        cyc(0, 0, 1, 8'h33, 1, "R3 after stall");
        drain();

        // R8: strobe together with a byte in mid-stream
        cyc(1, 32'h10, 1, 8'hF0, 1, "R8 page");
        cyc(0, 0, 1, 8'h0F, 1, "R8 page");
        cyc(1, 32'h20, 1, 8'hC3, 1, "R8 same-cycle reseed");
        drain();

        // R5: scramble, then descramble with the same address
        got.delete();
        cyc(1, 32'h0007_7000, 0, 0, 1, "R5 start");
        for (int i = 0; i < 24; i++) begin
            logic [7:0] v = 8'($urandom);
            orig.push_back(v);
            cyc(0, 0, 1, v, 1, "R5 scramble");
        end
        drain();
        begin
            logic [7:0] sc [$];
            sc = got;
            got.delete();
            cyc(1, 32'h0007_7000, 0, 0, 1, "R5 start");
            foreach (sc[i]) cyc(0, 0, 1, sc[i], 1, "R5 descramble");
            drain();
            foreach (orig[i]) check(got[i] === orig[i], "R5 round trip", got[i], orig[i]);
        end

        // random pages with gaps, stalls and strobes
        for (int p = 0; p < 300; p++) begin
            logic [31:0] a = $urandom;
            int n = 1 + ($urandom % 40);
            cyc(1, a, ($urandom % 2) == 0, 8'($urandom), 1, "R8 random start");
            for (int i = 0; i < n; i++) begin
                cyc(0, 0, ($urandom % 4) != 0, 8'($urandom), ($urandom % 10) < 7, "R2 random page");
            end
        end
        drain();
        check(expq.size() == 0, "R6 all delivered", expq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule